// File: doc/BRIEF.md
# Display Core Clock Enable Chain

This block turns a fast input clock into the enable pattern of a slower display core clock. Three stages run in a fixed order. First comes an integer divider whose ratio is picked by a short code from a small preset set. Next is a cycle squasher, which steps through a programmable bit waveform and removes each incoming pulse that meets a zero bit. Last comes a fixed halving stage. The chain never gates a clock. Its result is a single-cycle enable pulse for logic that runs on the input clock, plus a toggling level whose period equals the derived clock period.

The resulting rate is `f_in / ratio / (length / ones) / 2`. Here `ones` counts the set bits among the active waveform bits. The divider and the squasher can each be skipped, which removes that stage's factor from the equation. All settings are held in a shadow copy. That copy reloads only when the squasher completes a full waveform period, so a pattern is never applied halfway.

Top module: `dispclk_enable_chain`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `clk_en_out` and `clk_tgl_out` are both 0.
- R2: With the squasher skipped, `div_code` 0 divides by 1, 1 divides by 2 and 3 divides by 4. With code 3, `clk_en_out` pulses exactly once every 8 cycles.
- R3: The reserved `div_code` 2 acts as ratio 1.
- R4: The squasher uses waveform bit 0 first and then steps upward, one bit per divider pulse. A 1 bit passes the pulse and a 0 bit drops it. The long-run rate is ones/length.
- R5: The waveform length is `wave_len_m1`+1. Bits at or above that length are ignored.
- R6: If every active waveform bit is 0, the waveform is treated as all ones. The chain never stalls: no more than 16 consecutive divider pulses are dropped.
- R7: With `div_skip` set, the divider passes every input cycle, whatever `div_code` holds.
- R8: With `sq_skip` set, every divider pulse passes, whatever the waveform holds.
- R9: `clk_tgl_out` flips once for each squasher pulse. `clk_en_out` is a single-cycle pulse on every second squasher pulse, coinciding with the toggle falling to 0.
- R10: New settings apply only after the last bit of the current waveform period has been used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 2 | Preset divider select code |
| wave_bits | input | 16 | Squash waveform, bit 0 used first |
| wave_len_m1 | input | 4 | Waveform length minus one |
| div_skip | input | 1 | Skip the divider stage |
| sq_skip | input | 1 | Skip the squasher stage |
| clk_en_out | output | 1 | Single-cycle enable of the derived clock |
| clk_tgl_out | output | 1 | Level that toggles at each squasher pulse |

## Verification
The bench counts enables and toggles over windows that span whole periods. This catches a wrong ratio table entry, a reserved code that does not fall back to 1, a length that is off by one, or high waveform bits leaking into the pattern; each of these shifts the count by far more than one. An all-zero waveform is checked so that a design that stalls, and never pulses again, is caught. A waveform change made in mid-period is checked: a design that loads settings at once would toggle early during the remaining zero bits. The exact spacing of enables at ratio 4 exposes a divider counter that is off by one.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int RATIO_W = 3;

  // preset divider ratios; the reserved code falls back to 1
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      2'd1:    r = 3'd2;
      2'd3:    r = 3'd4;
      default: r = 3'd1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dcc_div.sv
module dcc_div
  import dcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               bypass,
  output logic               pulse
);
  logic [RATIO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    pulse = bypass | (cnt_q == (ratio - RATIO_W'(1)));
    cnt_d = pulse ? '0 : cnt_q + RATIO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dcc_squash.sv
module dcc_squash #(
  parameter int WAVE_W = 16,
  localparam int LEN_W = $clog2(WAVE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_pulse,
  input  logic [WAVE_W-1:0] wave,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              bypass,
  output logic              out_pulse,
  output logic              boundary
);
  logic [WAVE_W-1:0] mask, eff_wave;
  logic [LEN_W-1:0]  ptr_q, ptr_d;

  for (genvar i = 0; i < WAVE_W; i++) begin : g_mask
    assign mask[i] = (len_m1 >= LEN_W'(i));
  end

  always_comb begin
    eff_wave  = ((wave & mask) == '0) ? mask : wave;
    boundary  = in_pulse & (bypass | (ptr_q == len_m1));
    out_pulse = in_pulse & (bypass | eff_wave[ptr_q]);
    if (boundary)      ptr_d = '0;
    else if (in_pulse) ptr_d = ptr_q + LEN_W'(1);
    else               ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/dcc_half.sv
module dcc_half (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pulse,
  output logic en_out,
  output logic tgl_out
);
  logic half_q, half_d, en_q, en_d;

  always_comb begin
    half_d = in_pulse ? ~half_q : half_q;
    en_d   = in_pulse & half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      half_q <= half_d;
      en_q   <= en_d;
    end
  end

  assign en_out  = en_q;
  assign tgl_out = half_q;
endmodule

// File: rtl/dispclk_enable_chain.sv
module dispclk_enable_chain
  import dcc_pkg::*;
#(
  parameter int WAVE_W = 16,
  localparam int LEN_W = $clog2(WAVE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        div_code,
  input  logic [WAVE_W-1:0] wave_bits,
  input  logic [LEN_W-1:0]  wave_len_m1,
  input  logic              div_skip,
  input  logic              sq_skip,
  output logic              clk_en_out,
  output logic              clk_tgl_out
);
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // shadow settings, reloaded at waveform-period boundaries only
  logic [1:0]        code_q, code_d;
  logic [WAVE_W-1:0] wave_q, wave_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              dskip_q, dskip_d, sskip_q, sskip_d;
  logic              boundary, div_pulse, sq_pulse;

  always_comb begin
    code_d  = code_q;
    wave_d  = wave_q;
    len_d   = len_q;
    dskip_d = dskip_q;
    sskip_d = sskip_q;
    if (boundary) begin
      code_d  = div_code;
      wave_d  = wave_bits;
      len_d   = wave_len_m1;
      dskip_d = div_skip;
      sskip_d = sq_skip;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_q  <= 2'd0;
      wave_q  <= '1;
      len_q   <= '0;
      dskip_q <= 1'b0;
      sskip_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      wave_q  <= wave_d;
      len_q   <= len_d;
      dskip_q <= dskip_d;
      sskip_q <= sskip_d;
    end
  end

  dcc_div u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ratio  (ratio_of(code_q)),
    .bypass (dskip_q),
    .pulse  (div_pulse)
  );

  dcc_squash #(.WAVE_W(WAVE_W)) u_sq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_pulse  (div_pulse),
    .wave      (wave_q),
    .len_m1    (len_q),
    .bypass    (sskip_q),
    .out_pulse (sq_pulse),
    .boundary  (boundary)
  );

  dcc_half u_half (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_pulse(sq_pulse),
    .en_out  (clk_en_out),
    .tgl_out (clk_tgl_out)
  );
endmodule

// File: rtl/dcc_chain_chk.sv
module dcc_chain_chk #(
  parameter int WAVE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              tgl,
  input logic              boundary,
  input logic              div_pulse,
  input logic              sq_pulse,
  input logic [WAVE_W-1:0] act_wave
);
  localparam int DW = $clog2(WAVE_W) + 2;
  logic [DW-1:0] drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    drop_q <= '0;
    else if (sq_pulse)             drop_q <= '0;
    else if (div_pulse && drop_q != '1) drop_q <= drop_q + DW'(1);
  end

  assert_en_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> !en);
  assert_en_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (!tgl && $past(tgl)));
  assert_cfg_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(boundary) |-> $stable(act_wave));
  assert_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q <= DW'(WAVE_W));
endmodule

bind dispclk_enable_chain dcc_chain_chk #(.WAVE_W(WAVE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en        (clk_en_out),
  .tgl       (clk_tgl_out),
  .boundary  (boundary),
  .div_pulse (div_pulse),
  .sq_pulse  (sq_pulse),
  .act_wave  (wave_q)
);

// File: tb/sim_dispclk_enable_chain.sv
module sim_dispclk_enable_chain;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  div_code;
  logic [15:0] wave_bits;
  logic [3:0]  wave_len_m1;
  logic        div_skip, sq_skip;
  logic        clk_en_out, clk_tgl_out;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dispclk_enable_chain u0 (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .wave_bits(wave_bits),
    .wave_len_m1(wave_len_m1), .div_skip(div_skip), .sq_skip(sq_skip),
    .clk_en_out(clk_en_out), .clk_tgl_out(clk_tgl_out)
  );

  typedef struct packed {
    logic [1:0]  code;
    logic [15:0] wave;
    logic [3:0]  lm1;
    logic        dskip;
    logic        sskip;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'hFFFF, 4'd15, 1'b0, 1'b1},  // R2 ratio 1
    '{2'd1, 16'hFFFF, 4'd15, 1'b0, 1'b1},  // R2 ratio 2
    '{2'd3, 16'hFFFF, 4'd15, 1'b0, 1'b1},  // R2 ratio 4
    '{2'd2, 16'hFFFF, 4'd15, 1'b0, 1'b1},  // R3 reserved
    '{2'd0, 16'h00AA, 4'd7,  1'b0, 1'b0},  // R4 4 of 8
    '{2'd1, 16'h0015, 4'd4,  1'b0, 1'b0},  // R4 3 of 5
    '{2'd3, 16'hFFFF, 4'd15, 1'b1, 1'b0},  // R7 divider skipped
    '{2'd0, 16'hFF01, 4'd3,  1'b0, 1'b0},  // R5 high bits ignored
    '{2'd1, 16'h0000, 4'd7,  1'b0, 1'b0},  // R6 all zero
    '{2'd0, 16'hF000, 4'd3,  1'b0, 1'b0},  // R6 active bits zero
    '{2'd3, 16'h0003, 4'd2,  1'b0, 1'b1}   // R8 squasher skipped
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 2: return "R2";
      3:       return "R3";
      4, 5:    return "R4";
      6:       return "R7";
      7:       return "R5";
      8, 9:    return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic int bench_ratio(input vec_t v);
    if (v.dskip) return 1;
    case (v.code)
      2'd1:    return 2;
      2'd3:    return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int bench_len(input vec_t v);
    return v.sskip ? 1 : int'(v.lm1) + 1;
  endfunction

  function automatic int bench_ones(input vec_t v);
    int n = 0;
    if (v.sskip) return 1;
    for (int b = 0; b <= int'(v.lm1); b++) n += int'(v.wave[b]);
    return (n == 0) ? int'(v.lm1) + 1 : n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    div_code = v.code; wave_bits = v.wave; wave_len_m1 = v.lm1;
    div_skip = v.dskip; sq_skip = v.sskip;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int en_cnt, tg_cnt, back2back, gap, win, exp;
    logic prev_t, prev_e;
    rst_n = 1'b0;
    div_code = 2'd0; wave_bits = 16'hFFFF; wave_len_m1 = 4'd15;
    div_skip = 1'b0; sq_skip = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(clk_en_out == 1'b0, "R1 en in reset", int'(clk_en_out), 0);
    check(clk_tgl_out == 1'b0, "R1 tgl in reset", int'(clk_tgl_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(clk_en_out == 1'b0 && clk_tgl_out == 1'b0, "R1 after release",
          int'({clk_en_out, clk_tgl_out}), 0);

    // table of vectors: rate over whole periods
    back2back = 0;
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      repeat (150) @(negedge clk);
      win = 32 * bench_ratio(VECS[i]) * bench_len(VECS[i]);
      exp = 16 * bench_ones(VECS[i]);
      en_cnt = 0; tg_cnt = 0;
      prev_t = clk_tgl_out; prev_e = clk_en_out;
      for (int c = 0; c < win; c++) begin
        @(negedge clk);
        if (clk_en_out) en_cnt++;
        if (clk_tgl_out != prev_t) tg_cnt++;
        if (clk_en_out && prev_e) back2back++;
        prev_t = clk_tgl_out; prev_e = clk_en_out;
      end
      check(en_cnt >= exp - 1 && en_cnt <= exp + 1, {tag_of(i), " enable count"}, en_cnt, exp);
      check(tg_cnt >= 2 * exp - 1 && tg_cnt <= 2 * exp + 1, {tag_of(i), " R9 toggle count"},
            tg_cnt, 2 * exp);
    end
    check(back2back == 0, "R9 single-cycle enable", back2back, 0);

    // R2 exact spacing at ratio 4
    apply('{2'd3, 16'hFFFF, 4'd15, 1'b0, 1'b1});
    repeat (150) @(negedge clk);
    gap = 0;
    while (!clk_en_out && gap < 100) begin @(negedge clk); gap++; end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!clk_en_out && gap < 100);
    check(gap == 8, "R2 enable spacing ratio 4", gap, 8);

    // R10 mid-period change deferred to period end (also R4 bit 0 first)
    apply('{2'd0, 16'h0001, 4'd15, 1'b0, 1'b0});
    repeat (150) @(negedge clk);
    prev_t = clk_tgl_out;
    gap = 0;
    do begin @(negedge clk); gap++; end while (clk_tgl_out == prev_t && gap < 100);
    check(gap < 100, "R4 pattern toggles", gap, 16);
    wave_bits = 16'hFFFF;
    prev_t = clk_tgl_out;
    tg_cnt = 0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (clk_tgl_out != prev_t) tg_cnt++;
      prev_t = clk_tgl_out;
    end
    check(tg_cnt == 0, "R10 old pattern kept to period end", tg_cnt, 0);
    @(negedge clk);
    check(clk_tgl_out != prev_t, "R10 new pattern bit 0", int'(clk_tgl_out), int'(!prev_t));
    prev_t = clk_tgl_out;
    @(negedge clk);
    check(clk_tgl_out != prev_t, "R10 new pattern bit 1", int'(clk_tgl_out), int'(!prev_t));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule